// File: doc/BRIEF.md
# Timekeeping Register Window

This block holds eight byte-wide clock and control registers that answer at the eight highest addresses of a byte-addressed memory space. It sits between a synchronous host read/write port and an external running time counter. The counter supplies its live BCD time fields every cycle. The block keeps a host-visible shadow copy of those fields. On each once-per-second strobe it refreshes that copy. A hold bit freezes the shadow so that software reads one consistent snapshot. A load bit opens the time fields to host writes and hands the loaded values back to the counter when it is cleared.

Control flags share the spare bits of the time registers. These flags are an oscillator-halt flag, which is routed out to the counter, a frequency-test flag and a read-only battery-good flag. The remaining spare bits behave as plain storage.

Register index is address bits [2:0] inside the window. The indexes are: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. The time-field bits of each register are:

| Index | Time-field bits | Mask |
|---|---|---|
| 0 | [5:0] | 0x3F |
| 1 | [6:0] | 0x7F |
| 2 | [6:0] | 0x7F |
| 3 | [5:0] | 0x3F |
| 4 | [2:0] | 0x07 |
| 5 | [5:0] | 0x3F |
| 6 | [4:0] | 0x1F |
| 7 | [7:0] | 0xFF |

Top module: `tkw_window`

## Requirements
- R1: An access hits the window only when `bus_sel` is 1 and every address bit above bit 2 is 1. Bits [2:0] select the register index. A read hit returns the byte on `bus_rdata` with `bus_rvalid`=1 in the cycle after the request. Any other access produces no `bus_rvalid` and changes no register.
- R2: While the hold bit (index 0, bit 6) is 1, the time fields read back hold the values they had when the bit was set, whatever `live_time` and `tick_sec` do.
- R3: The load bit is index 0, bit 7. When a host write takes it from 1 to 0, `commit_stb` is 1 for exactly one cycle, in the cycle after that write. `commit_time` then carries the time fields of all eight registers (byte i = register i, masked to its time-field bits). No commit happens at any other time.
- R4: A host write to a time field is ignored unless the load bit was already 1 before that write.
- R5: On a `tick_sec` strobe with both the hold bit and the load bit at 0, every time field takes its value from `live_time` byte i, all in the same cycle. Otherwise a strobe leaves them unchanged.
- R6: The oscillator-halt bit (index 1, bit 7) is host read/write and drives `osc_halt`.
- R7: The frequency-test bit is index 4, bit 6. While it is 1 and the halt bit is 0, a read of index 1 returns bit 0 from a phase flop that flips on each `tick_1k` strobe (512 Hz for a 1024 Hz strobe). The phase flop holds while halted. Otherwise bit 0 reads as stored.
- R8: Index 4, bit 7 reads as the inverse of `batt_low` and ignores writes.
- R9: The spare bits store host writes whatever the load bit is, and the refresh never alters them. The spare bits are index 2 bit 7, index 3 bits 7:6, index 4 bits 5:3, index 5 bits 7:6 and index 6 bits 7:5.
- R10: With both the hold and load bits set, clearing only the load bit still commits. Clearing only the hold bit never commits.
- R11: After reset every stored bit is 0, and `commit_stb`, `bus_rvalid` and `osc_halt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read hit |
| tick_sec | input | 1 | Once-per-second strobe from the counter |
| tick_1k | input | 1 | 1024 Hz strobe for the frequency test |
| batt_low | input | 1 | Battery exhausted indication |
| live_time | input | 64 | Live counter fields, byte i for register i |
| commit_stb | output | 1 | One-cycle load request to the counter |
| commit_time | output | 64 | Values to load, byte i for register i |
| osc_halt | output | 1 | Oscillator stop request |

## Verification
The bench targets the load-bit falling edge. A design that commits on the rising edge, or on clearing the hold bit, would push stale values into the counter. One that drops the century written in the clearing write would commit the wrong byte. Time-field writes made with the load bit clear are aimed at designs that let stray writes corrupt the snapshot. Seconds strobes issued while the hold or load bit is set expose a shadow that keeps refreshing. Reads of the weekday and seconds registers with the battery input and the test flag toggled catch a stored battery bit, or a test phase that leaks through while the oscillator is halted.

// File: rtl/tkw_pkg.sv
package tkw_pkg;
  localparam int REG_N  = 8;
  localparam int IDX_W  = $clog2(REG_N);
  localparam int BYTE_W = 8;
  localparam int BUS_W  = REG_N * BYTE_W;

  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_WDAY = 3'd4;

  localparam int LOAD_BIT = 7;  // index 0
  localparam int HOLD_BIT = 6;  // index 0
  localparam int HALT_BIT = 7;  // index 1
  localparam int TEST_BIT = 6;  // index 4
  localparam int BATT_BIT = 7;  // index 4

  // bits carried from / to the running counter
  function automatic logic [BYTE_W-1:0] time_mask(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    time_mask = 8'h3F;
      3'd1:    time_mask = 8'h7F;
      3'd2:    time_mask = 8'h7F;
      3'd3:    time_mask = 8'h3F;
      3'd4:    time_mask = 8'h07;
      3'd5:    time_mask = 8'h3F;
      3'd6:    time_mask = 8'h1F;
      default: time_mask = 8'hFF;
    endcase
  endfunction

  // control and spare bits, writable at any time
  function automatic logic [BYTE_W-1:0] free_mask(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    free_mask = 8'hC0;
      3'd1:    free_mask = 8'h80;
      3'd2:    free_mask = 8'h80;
      3'd3:    free_mask = 8'hC0;
      3'd4:    free_mask = 8'h78;
      3'd5:    free_mask = 8'hC0;
      3'd6:    free_mask = 8'hE0;
      default: free_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tkw_decode.sv
module tkw_decode #(
  parameter int ADDR_W = 17
) (
  input  logic                       sel,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       wr_en,
  output logic                       rd_en,
  output logic [tkw_pkg::IDX_W-1:0]  idx
);
  import tkw_pkg::*;
  localparam int UP_W = ADDR_W - IDX_W;

  logic in_win;

  always_comb begin
    in_win = sel && (&addr[ADDR_W-1:IDX_W]);
    wr_en  = in_win && we;
    rd_en  = in_win && !we;
    idx    = addr[IDX_W-1:0];
  end

  initial begin
    if (UP_W < 1) $error("ADDR_W must exceed the index width");
  end
endmodule

// File: rtl/tkw_shadow.sv
module tkw_shadow (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         wr_en,
  input  logic [tkw_pkg::IDX_W-1:0]                    idx,
  input  logic [tkw_pkg::BYTE_W-1:0]                   wdata,
  input  logic                                         tick_sec,
  input  logic [tkw_pkg::BUS_W-1:0]                    live_time,
  output logic [tkw_pkg::REG_N-1:0][tkw_pkg::BYTE_W-1:0] bank,
  output logic                                         commit_stb,
  output logic [tkw_pkg::BUS_W-1:0]                    commit_time
);
  import tkw_pkg::*;

  logic [REG_N-1:0][BYTE_W-1:0] sh_q;
  logic [REG_N-1:0][BYTE_W-1:0] sh_d;
  logic [BUS_W-1:0]             load_vec;
  logic [BUS_W-1:0]             tf_vec;
  logic [BUS_W-1:0]             sp_vec;
  logic                         load_q;
  logic                         hold_q;
  logic                         refresh;
  logic                         load_fall;

  assign load_q    = sh_q[IDX_CTRL][LOAD_BIT];
  assign hold_q    = sh_q[IDX_CTRL][HOLD_BIT];
  assign refresh   = tick_sec && !load_q && !hold_q;
  assign load_fall = load_q && !sh_d[IDX_CTRL][LOAD_BIT];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] TM = time_mask(IDX_W'(g));
    localparam logic [BYTE_W-1:0] FM = free_mask(IDX_W'(g));
    logic [BYTE_W-1:0] wmask;
    logic [BYTE_W-1:0] after_ref;

    always_comb begin
      wmask     = FM | (load_q ? TM : '0);
      after_ref = refresh ? ((sh_q[g] & ~TM) | (live_time[g*BYTE_W +: BYTE_W] & TM))
                          : sh_q[g];
      if (wr_en && (idx == IDX_W'(g)))
        sh_d[g] = (after_ref & ~wmask) | (wdata & wmask);
      else
        sh_d[g] = after_ref;
    end

    assign load_vec[g*BYTE_W +: BYTE_W] = sh_d[g] & TM;
    assign tf_vec[g*BYTE_W +: BYTE_W]   = sh_q[g] & TM;
    assign sp_vec[g*BYTE_W +: BYTE_W]   = sh_q[g] & FM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      commit_stb  <= 1'b0;
      commit_time <= '0;
    end else begin
      sh_q       <= sh_d;
      commit_stb <= load_fall;
      if (load_fall) commit_time <= load_vec;
    end
  end

  assign bank = sh_q;

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    $past(hold_q && !load_q && !wr_en) |-> (tf_vec == $past(tf_vec))); // R2
  AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    commit_stb |-> ($past(load_q) && !load_q)); // R3
  AST_NO_COMMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (load_q && $past(load_q)) |-> !commit_stb); // R3
  AST_TIME_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    $past(!load_q && !refresh) |-> (tf_vec == $past(tf_vec))); // R4
  AST_SPARE_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_en) |-> (sp_vec == $past(sp_vec))); // R9
endmodule

// File: rtl/tkw_readmux.sv
module tkw_readmux (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         rd_en,
  input  logic [tkw_pkg::IDX_W-1:0]                    idx,
  input  logic [tkw_pkg::REG_N-1:0][tkw_pkg::BYTE_W-1:0] bank,
  input  logic                                         batt_low,
  input  logic                                         tick_1k,
  output logic [tkw_pkg::BYTE_W-1:0]                   rdata,
  output logic                                         rvalid
);
  import tkw_pkg::*;

  logic              phase_q;
  logic              halted;
  logic              test_on;
  logic [BYTE_W-1:0] fmt;

  assign halted  = bank[IDX_SEC][HALT_BIT];
  assign test_on = bank[IDX_WDAY][TEST_BIT] && !halted;

  always_comb begin
    fmt = bank[idx];
    if (idx == IDX_WDAY) fmt[BATT_BIT] = !batt_low;
    if ((idx == IDX_SEC) && test_on) fmt[0] = phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      if (tick_1k && !halted) phase_q <= !phase_q;
      rvalid <= rd_en;
      if (rd_en) rdata <= fmt;
    end
  end

  AST_BATT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rvalid && $past(idx) == IDX_WDAY) |-> (rdata[BATT_BIT] == !$past(batt_low))); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(halted) |-> (phase_q == $past(phase_q))); // R7
endmodule

// File: rtl/tkw_window.sv
module tkw_window #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic              tick_sec,
  input  logic              tick_1k,
  input  logic              batt_low,
  input  logic [63:0]       live_time,
  output logic              commit_stb,
  output logic [63:0]       commit_time,
  output logic              osc_halt
);
  import tkw_pkg::*;

  logic                         wr_en;
  logic                         rd_en;
  logic [IDX_W-1:0]             idx;
  logic [REG_N-1:0][BYTE_W-1:0] bank;

  tkw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel   (bus_sel),
    .we    (bus_we),
    .addr  (bus_addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .idx   (idx)
  );

  tkw_shadow u_shadow (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .idx         (idx),
    .wdata       (bus_wdata),
    .tick_sec    (tick_sec),
    .live_time   (live_time),
    .bank        (bank),
    .commit_stb  (commit_stb),
    .commit_time (commit_time)
  );

  tkw_readmux u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .idx      (idx),
    .bank     (bank),
    .batt_low (batt_low),
    .tick_1k  (tick_1k),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  assign osc_halt = bank[IDX_SEC][HALT_BIT];

  AST_RVALID_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_we && (&bus_addr[ADDR_W-1:IDX_W]))); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!commit_stb && !bus_rvalid && !osc_halt)); // R11
endmodule

// File: tb/tkw_window_bench.sv
module tkw_window_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 17;
  localparam logic [AW-1:0] TOP = {{(AW-3){1'b1}}, 3'b000};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_rvalid;
  logic          tick_sec = 1'b0, tick_1k = 1'b0, batt_low = 1'b0;
  logic [63:0]   live_time = '0;
  logic          commit_stb;
  logic [63:0]   commit_time;
  logic          osc_halt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m [8];
  bit         phase;
  logic [7:0] last_rd;

  always #(CLK_P/2) clk = ~clk;

  tkw_window #(.ADDR_W(AW)) u_tkw_window (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tick_sec(tick_sec), .tick_1k(tick_1k), .batt_low(batt_low), .live_time(live_time),
    .commit_stb(commit_stb), .commit_time(commit_time), .osc_halt(osc_halt)
  );

  function automatic logic [7:0] tm(input int i);
    case (i)
      0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
      4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fm(input int i);
    case (i)
      0: return 8'hC0; 1: return 8'h80; 2: return 8'h80; 3: return 8'hC0;
      4: return 8'h78; 5: return 8'hC0; 6: return 8'hE0; default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle with model update; checks at the following falling edge
  task automatic step(input bit sel, input bit we, input logic [AW-1:0] addr,
                      input logic [7:0] wd, input bit ts, input bit tk);
    bit         hit, pw, ph, posc, pft, exp_rv, exp_cs;
    int         ix;
    logic [7:0] exp_rd, wmk;
    logic [63:0] exp_ct;
    string      tag;
    hit  = sel && (&addr[AW-1:3]);
    ix   = int'(addr[2:0]);
    pw   = m[0][7]; ph = m[0][6]; posc = m[1][7]; pft = m[4][6];
    exp_rv = hit && !we;
    exp_rd = m[ix];
    tag = "R1";
    if (ix == 4) begin exp_rd[7] = !batt_low; tag = "R8"; end
    if (ix == 1 && pft && !posc) begin exp_rd[0] = phase; tag = "R7"; end
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
    tick_sec = ts; tick_1k = tk;
    @(posedge clk);
    if (ts && !pw && !ph)
      for (int i = 0; i < 8; i++) m[i] = (m[i] & ~tm(i)) | (live_time[i*8 +: 8] & tm(i));
    if (hit && we) begin
      wmk = fm(ix) | (pw ? tm(ix) : 8'h00);
      m[ix] = (m[ix] & ~wmk) | (wd & wmk);
    end
    if (tk && !posc) phase = !phase;
    exp_cs = pw && !m[0][7];
    exp_ct = '0;
    for (int i = 0; i < 8; i++) exp_ct[i*8 +: 8] = m[i] & tm(i);
    @(negedge clk);
    chk("R1 rvalid", {63'b0, bus_rvalid}, {63'b0, exp_rv});
    if (exp_rv) begin chk(tag, {56'b0, bus_rdata}, {56'b0, exp_rd}); last_rd = bus_rdata; end
    chk("R3 stb", {63'b0, commit_stb}, {63'b0, exp_cs});
    if (exp_cs) chk("R3 data", commit_time, exp_ct);
    chk("R6", {63'b0, osc_halt}, {63'b0, m[1][7]});
    bus_sel = 1'b0; bus_we = 1'b0; tick_sec = 1'b0; tick_1k = 1'b0;
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    step(1, 1, TOP | AW'(i), d, 0, 0);
  endtask
  task automatic rd(input int i);
    step(1, 0, TOP | AW'(i), 8'h00, 0, 0);
  endtask
  task automatic idle(input bit ts, input bit tk);
    step(0, 0, '0, 8'h00, ts, tk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    phase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 osc", {63'b0, osc_halt}, 64'd0);
    chk("R11 stb", {63'b0, commit_stb}, 64'd0);
    chk("R11 rvalid", {63'b0, bus_rvalid}, 64'd0);
    for (int i = 0; i < 8; i++) rd(i);

    // R4 time writes ignored while load bit clear, R9 spare kept
    wr(2, 8'h59); rd(2); chk("R4", {56'b0, last_rd}, 64'h00);
    wr(2, 8'hD9); rd(2); chk("R9", {56'b0, last_rd}, 64'h80);

    // R5 refresh on strobe
    live_time = 64'h99_12_31_07_23_59_45_20;
    idle(1, 0); rd(2); chk("R5", {56'b0, last_rd}, 64'hD9);
    rd(7); chk("R5 year", {56'b0, last_rd}, 64'h99);

    // R3 load sequence with a strobe that must not refresh
    wr(0, 8'h80); wr(1, 8'h45); wr(7, 8'h42);
    live_time = 64'h11_11_11_01_11_11_11_11;
    idle(1, 0); rd(7); chk("R5 no refresh in load", {56'b0, last_rd}, 64'h42);
    wr(0, 8'h21);
    chk("R3 pulse", {63'b0, commit_stb}, 64'd1);
    chk("R3 year", {56'b0, commit_time[63:56]}, 64'h42);
    chk("R3 century", {56'b0, commit_time[7:0]}, 64'h21);
    idle(0, 0); chk("R3 single", {63'b0, commit_stb}, 64'd0);

    // R2 hold bit freezes snapshot
    live_time = 64'h20_05_14_03_08_30_10_20;
    idle(1, 0); wr(0, 8'h40);
    live_time = 64'h21_06_15_04_09_31_11_20;
    idle(1, 0); idle(1, 0); rd(3); chk("R2", {56'b0, last_rd}, 64'h08);
    wr(0, 8'h00); chk("R10 hold clear no commit", {63'b0, commit_stb}, 64'd0);
    idle(1, 0); rd(3); chk("R5 after hold", {56'b0, last_rd}, 64'h09);

    // R10 both bits set, clearing load commits
    wr(0, 8'hC0); wr(3, 8'h12); wr(0, 8'h40);
    chk("R10 commit", {63'b0, commit_stb}, 64'd1);
    chk("R10 hours", {56'b0, commit_time[31:24]}, 64'h12);
    wr(0, 8'h00); chk("R10 no commit", {63'b0, commit_stb}, 64'd0);

    // R6 / R7 oscillator halt and frequency test
    wr(1, 8'h80); chk("R6 halt", {63'b0, osc_halt}, 64'd1);
    wr(4, 8'h40);
    rd(1); a0 = last_rd; idle(0, 1); rd(1);
    chk("R7 halted no toggle", {63'b0, last_rd[0]}, {63'b0, a0[0]});
    wr(1, 8'h00); chk("R6 run", {63'b0, osc_halt}, 64'd0);
    rd(1); a0 = last_rd; idle(0, 1); rd(1);
    chk("R7 toggle", {63'b0, last_rd[0]}, {63'b0, !a0[0]});

    // R8 battery flag
    batt_low = 1'b1; wr(4, 8'hC0); rd(4); chk("R8 low", {63'b0, last_rd[7]}, 64'd0);
    batt_low = 1'b0; rd(4); chk("R8 good", {63'b0, last_rd[7]}, 64'd1);

    // R1 off-window accesses
    step(1, 0, 17'h00012, 8'h00, 0, 0);
    step(1, 1, 17'h0FFFA, 8'hFF, 0, 0);
    step(0, 1, TOP | 17'd2, 8'h00, 0, 0);
    rd(2);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [AW-1:0] ad;
      op = $urandom_range(0, 9);
      live_time = {$urandom, $urandom};
      if ($urandom_range(0, 15) == 0) batt_low = ~batt_low;
      ad = TOP | AW'($urandom_range(0, 7));
      if (op == 8) ad = AW'($urandom);
      step(op != 9, (op >= 4 && op <= 7) || (op == 8 && $urandom_range(0, 1) == 1), ad,
           8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule